// File: doc/BRIEF.md
# Timed Event Counter with Expiry Freeze and Read Restart

This block keeps a live counter that advances by one on every system clock cycle and wraps back to zero after it reaches a parameterised top value. Next to it runs a timebase that counts system clock cycles up to one period of a parameterised frequency, which is one second of real time. When the timebase reaches its end value it stops there, and the block presents the count as valid.

The count leaves the block on a valid/ready pair. `cnt_valid` stays high until a consumer pulses `rd_ready`. A transfer takes place on a clock edge where both are high. That transfer restarts the timebase from zero, and `cnt_valid` falls on the same edge. If the consumer does not take the value, `cnt_valid` stays high for as long as it waits. A `rd_ready` pulse while `cnt_valid` is low does nothing.

The mode parameter picks one of two variants:
- **Freeze mode.** The live counter stops while the count is valid, so the presented value does not change until it is taken.
- **Snapshot mode.** The live counter never stops. An accepted read copies it into a separate register, and `cnt_data` shows that register.

Top module: `timed_counter`

## Requirements
- R1: While `rst` (asynchronous, active high) is asserted, the live count and the timebase are zero. `cnt_data` reads 0 and `cnt_valid` reads 0.
- R2: While `cnt_valid` is low, the live count rises by exactly one on each clock edge, and it goes from EVT_MAX to 0.
- R3: `cnt_valid` rises exactly CLK_HZ clock edges after reset release or after an accepted read. It is driven high while the timebase sits at CLK_HZ.
- R4: In freeze mode (MODE = MODE_FREEZE), while `cnt_valid` is high and no read is accepted, `cnt_data` keeps its value. The one exception is the wrap in R5.
- R5: The wrap takes priority over the freeze. A count at EVT_MAX goes to 0 on the next edge even while `cnt_valid` is high, and it then stays at 0.
- R6: An edge with `rd_ready` and `cnt_valid` both high restarts the timebase from 0 and drives `cnt_valid` low after that edge. In freeze mode, the live count still holds on that edge and advances again on the edge after it.
- R7: A `rd_ready` pulse while `cnt_valid` is low has no effect: the timebase keeps counting, and the rise of `cnt_valid` is not moved.
- R8: In snapshot mode (MODE = MODE_SNAPSHOT), the live count never holds. `cnt_data` takes the live count present at each accepted read and keeps it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| rd_ready | input | 1 | Consumer ready; a transfer occurs on an edge where it and `cnt_valid` are both high |
| cnt_data | output | $clog2(EVT_MAX+1) | Presented count: the live count in freeze mode, the captured count in snapshot mode |
| cnt_valid | output | 1 | The timebase has expired and the count is available |

## Verification
The assertions assume that `rd_ready` is a single-cycle pulse. They also assume that the block always lives through at least one edge between reset release and any check of a $past value. The stimulus drives `rd_ready` only at falling clock edges, as one-cycle pulses, from a seeded random draw plus a few directed pulses. Some pulses land while the count is valid and some while it is not, so both accepted reads and ignored reads appear. The timebase is shortened, and it is chosen so that the first expiry meets the live count at its top value, which exercises the wrap-over-freeze priority.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic {
    MODE_FREEZE   = 1'b0,
    MODE_SNAPSHOT = 1'b1
  } tmc_mode_e;
endpackage

// File: rtl/tmc_timebase.sv
module tmc_timebase #(
  parameter int CLK_HZ = 50_000_000,
  localparam int TICK_W = $clog2(CLK_HZ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [TICK_W-1:0] tick_q,
  output logic              expired
);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(CLK_HZ);

  assign expired = (tick_q == TICK_END);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tick_q <= '0;
    end else if (expired) begin
      if (restart) tick_q <= '0;
    end else begin
      tick_q <= tick_q + TICK_W'(1);
    end
  end
endmodule

// File: rtl/tmc_event_cnt.sv
module tmc_event_cnt #(
  parameter int EVT_MAX = 1000,
  localparam int CNT_W = $clog2(EVT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(EVT_MAX);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_TOP) begin
      cnt_q <= '0;
    end else if (!hold) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/timed_counter.sv
module timed_counter
  import tmc_pkg::*;
#(
  parameter int        EVT_MAX = 1000,
  parameter int        CLK_HZ  = 50_000_000,
  parameter tmc_mode_e MODE    = MODE_FREEZE,
  localparam int CNT_W  = $clog2(EVT_MAX + 1),
  localparam int TICK_W = $clog2(CLK_HZ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ready,
  output logic [CNT_W-1:0] cnt_data,
  output logic             cnt_valid
);
  logic [TICK_W-1:0] tick_w;
  logic [CNT_W-1:0]  live_cnt;
  logic              expired_w;
  logic              hold_w;

  tmc_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .restart (rd_ready),
    .tick_q  (tick_w),
    .expired (expired_w)
  );

  assign hold_w = (MODE == MODE_FREEZE) && expired_w;

  tmc_event_cnt #(.EVT_MAX(EVT_MAX)) u_evt (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold_w),
    .cnt_q (live_cnt)
  );

  assign cnt_valid = expired_w;

  generate
    if (MODE == MODE_SNAPSHOT) begin : g_snap
      logic [CNT_W-1:0] snap_q;
      logic             take;
      assign take = rd_ready && expired_w;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)       snap_q <= '0;
        else if (take) snap_q <= live_cnt;
      end
      assign cnt_data = snap_q;
    end else begin : g_freeze
      assign cnt_data = live_cnt;
    end
  endgenerate
endmodule

// File: rtl/timed_counter_chk.sv
module timed_counter_chk
  import tmc_pkg::*;
#(
  parameter int        EVT_MAX = 1000,
  parameter int        CLK_HZ  = 50_000_000,
  parameter tmc_mode_e MODE    = MODE_FREEZE,
  localparam int CNT_W  = $clog2(EVT_MAX + 1),
  localparam int TICK_W = $clog2(CLK_HZ + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_ready,
  input logic              cnt_valid,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [TICK_W-1:0] tick
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(EVT_MAX);
  localparam bit FRZ = (MODE == MODE_FREEZE);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_valid && live_cnt != CNT_TOP) |=> (live_cnt == $past(live_cnt) + CNT_W'(1)));

  assert_wrap_first_R5: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == CNT_TOP) |=> (live_cnt == '0));

  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (FRZ && cnt_valid && live_cnt != CNT_TOP) |=> $stable(live_cnt));

  assert_valid_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_valid && !rd_ready) |=> cnt_valid);

  assert_take_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_valid && rd_ready) |=> (!cnt_valid && tick == '0));

  assert_idle_read_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!cnt_valid && rd_ready) |=> (tick == $past(tick) + TICK_W'(1)));
endmodule

bind timed_counter timed_counter_chk #(
  .EVT_MAX (EVT_MAX),
  .CLK_HZ  (CLK_HZ),
  .MODE    (MODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_ready  (rd_ready),
  .cnt_valid (cnt_valid),
  .live_cnt  (live_cnt),
  .tick      (tick_w)
);

// File: tb/timed_counter_tb.sv
module timed_counter_tb;
  import tmc_pkg::*;
  localparam int PERIOD  = 10;
  localparam int EVT_MAX = 13;
  localparam int CLK_HZ  = 41;
  localparam int CNT_W   = $clog2(EVT_MAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd  = 1'b0;
  logic [CNT_W-1:0] f_data, s_data;
  logic f_valid, s_valid;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_tick_f, m_cnt_f, m_tick_s, m_cnt_s, m_snap;

  always #(PERIOD/2) clk = ~clk;

  timed_counter #(.EVT_MAX(EVT_MAX), .CLK_HZ(CLK_HZ), .MODE(MODE_FREEZE)) u_dut (
    .clk(clk), .rst(rst), .rd_ready(rd), .cnt_data(f_data), .cnt_valid(f_valid));

  timed_counter #(.EVT_MAX(EVT_MAX), .CLK_HZ(CLK_HZ), .MODE(MODE_SNAPSHOT)) u_snap (
    .clk(clk), .rst(rst), .rd_ready(rd), .cnt_data(s_data), .cnt_valid(s_valid));

  function automatic int nxt_tick(int t, bit r);
    if (t == CLK_HZ) return r ? 0 : t;
    return t + 1;
  endfunction

  function automatic int nxt_cnt(int c, bit hold);
    if (c == EVT_MAX) return 0;
    return hold ? c : c + 1;
  endfunction

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_tick_f <= 0; m_cnt_f <= 0; m_tick_s <= 0; m_cnt_s <= 0; m_snap <= 0;
    end else begin
      m_tick_f <= nxt_tick(m_tick_f, rd);
      m_cnt_f  <= nxt_cnt(m_cnt_f, m_tick_f == CLK_HZ);
      m_tick_s <= nxt_tick(m_tick_s, rd);
      m_cnt_s  <= nxt_cnt(m_cnt_s, 1'b0);
      if (rd && m_tick_s == CLK_HZ) m_snap <= m_cnt_s;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R3 valid freeze", int'(f_valid), int'(m_tick_f == CLK_HZ));
    chk(m_tick_f == CLK_HZ ? "R4 count" : "R2 count", int'(f_data), m_cnt_f);
    chk("R3 valid snapshot", int'(s_valid), int'(m_tick_s == CLK_HZ));
    chk("R8 snapshot data", int'(s_data), m_snap);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    #(PERIOD * 3);
    @(negedge clk);
    chk("R1 reset data", int'(f_data), 0);
    chk("R1 reset valid", int'(f_valid), 0);
    chk("R1 reset snap data", int'(s_data), 0);
    rst = 1'b0;
    // k counts edges after reset release
    for (int k = 1; k <= 45; k++) begin
      rd = (k == 5);            // R7: pulse while valid is low
      step();
      if (k == 40) chk("R7 still low", int'(f_valid), 0);
      if (k == 41) begin
        chk("R7 valid on time", int'(f_valid), 1);
        chk("R5 frozen at top", int'(f_data), EVT_MAX);
      end
      if (k == 42) chk("R5 wrapped while frozen", int'(f_data), 0);
      if (k == 45) chk("R5 held at zero", int'(f_data), 0);
    end
    rd = 1'b1;
    step();
    rd = 1'b0;
    chk("R6 valid dropped", int'(f_valid), 0);
    chk("R6 count held on take", int'(f_data), 0);
    step();
    chk("R6 count resumes", int'(f_data), 1);
    for (int i = 0; i < 1500; i++) begin
      rd = (($urandom % 5) == 0);
      step();
      rd = 1'b0;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule